// File: doc/BRIEF.md
# Eight-bit accumulator processor core

This block is a single-cycle 8-bit processor with a one-stage fetch pipeline. On each clock it fetches a 16-bit instruction word from an internal program store at the program counter. The high byte is the opcode byte and the low byte is an immediate. In the same clock it executes the word fetched on the previous clock. The architectural state is the program counter (16 bits), the accumulator, two index registers X and Y, and an output register that drives the output port. The block drives an external 32K x 8 data RAM through an address, a write strobe and a write data bus, and reads that RAM asynchronously.

Each opcode byte holds three fields: an ALU operation, an addressing/destination mode and a bus source. Conditional branches test the accumulator for sign and zero. The outcome selects one bit of the mode field, and that bit decides whether the branch is taken. The program store is filled through a load port that only works while reset is held, so that a surrounding test environment can put a program in place.

Sequencing uses a two-state phase machine. PH_RESET is held while `rst` is high and lasts for the first clock after it. PH_RUN is the normal execute state. The only transitions are PH_RESET to PH_RUN on the first clock with `rst` low, and any state to PH_RESET when `rst` is high. In PH_RESET the first word is fetched and nothing is executed.

Top module: `octet_cpu`

## Requirements
- R1: While `rst` is high, the program counter, accumulator, X, Y, output register and latched instruction word are all zero. On the first clock after `rst` falls, only the word at address 0 is fetched and the counter moves to 1. Nothing is written and no register is loaded.
- R2: The load port writes `prog_data` into program address `prog_addr` on a clock when both `prog_we` and `rst` are high. When `rst` is low, `prog_we` has no effect on the stored program.
- R3: In PH_RUN each clock executes the word latched on the previous clock and latches the word at the current counter value. The counter advances by 1 modulo 65536 unless a branch is taken. The word after a branch is always executed.
- R4: The opcode is bits 7:5 of the opcode byte: 0 load bus, 1 AND, 2 OR, 3 XOR, 4 add, 5 subtract (accumulator minus bus). All results are modulo 256.
- R5: The mode is bits 4:2 for opcodes 0 to 6. The table gives address {high:low} and destination: 0 {0:imm} acc; 1 {0:X} acc; 2 {Y:imm} acc; 3 {Y:X} acc; 4 {0:imm} X; 5 {0:imm} Y; 6 {0:imm} out; 7 {Y:X} out. The RAM address is the low 15 bits. Branches address {0:imm}.
- R6: The bus source is bits 1:0 of the opcode byte: 0 immediate, 1 RAM at the computed address, 2 accumulator, 3 `in_port`. On a store, source 1 drives 8'hFF.
- R7: Opcode 6 writes the bus value to RAM and loads neither the accumulator nor the output register. Modes 4 and 5 still load X or Y with the accumulator value.
- R8: Mode 7 (for opcodes 0 to 6) leaves X = X+1 modulo 256 after the instruction.
- R9: Opcode 7 with mode 0 sets the counter to {Y, bus}.
- R10: Opcode 7 with a nonzero mode forms an index: 0 if the accumulator is positive, 1 if bit 7 is set, 2 if it is zero. When mode bit [index] is 1, only the counter's low byte is replaced by the bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables program loading |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | ROM_AW | Program store write address |
| prog_data | input | 16 | Program word, opcode byte in bits 15:8 |
| in_port | input | 8 | Input port, bus source 3 |
| out_port | output | 8 | Output register |
| ram_addr | output | 15 | Data RAM address |
| ram_wdata | output | 8 | Data RAM write data (the bus value) |
| ram_we | output | 1 | Data RAM write strobe |
| ram_rdata | input | 8 | Data RAM asynchronous read data |
| fetch_addr | output | 16 | Program counter, the current fetch address |

## Verification
The bench builds the core with its default parameters. With an 8-bit data path and a 256-word program store, any counter value above 255 folds onto the same store, so far jumps that change the counter's high byte can be reached by a short program. A directed prelude walks through every operation, mode, source and branch outcome. After that the rest of the store holds pseudo-random words, so random branches, stores and X increments run for thousands of cycles. During that run, stray load-port writes check that the program cannot be altered outside reset.

// File: rtl/octet_pkg.sv
package octet_pkg;

    typedef enum logic [2:0] {
        OP_LD  = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_ADD = 3'd4,
        OP_SUB = 3'd5,
        OP_ST  = 3'd6,
        OP_BR  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_MEM = 2'd1,
        SRC_ACC = 2'd2,
        SRC_IN  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_ACC  = 3'd1,
        DST_X    = 3'd2,
        DST_Y    = 3'd3,
        DST_OUT  = 3'd4
    } dst_e;

    typedef enum logic {
        PH_RESET = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

    typedef struct packed {
        op_e        op;
        logic [2:0] mode;
        src_e       src;
        dst_e       dst;
        logic       lo_from_x;
        logic       hi_from_y;
        logic       bump_x;
        logic       is_store;
        logic       is_branch;
        logic       far_jump;
    } ctrl_t;

endpackage

// File: rtl/octet_progmem.sv
module octet_progmem #(
    parameter int AW = 8,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [WW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [WW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Registered read: this register is the instruction latch.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= store[rd_addr];
        end
    end
endmodule

// File: rtl/octet_decode.sv
module octet_decode
    import octet_pkg::*;
(
    input  logic [7:0] ir,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl           = '0;
        ctrl.op        = op_e'(ir[7:5]);
        ctrl.mode      = ir[4:2];
        ctrl.src       = src_e'(ir[1:0]);
        ctrl.is_store  = (ctrl.op == OP_ST);
        ctrl.is_branch = (ctrl.op == OP_BR);
        ctrl.far_jump  = ctrl.is_branch && (ctrl.mode == 3'd0);
        ctrl.dst       = DST_NONE;

        if (!ctrl.is_branch) begin
            unique case (ctrl.mode)
                3'd0: begin
                    ctrl.dst = ctrl.is_store ? DST_NONE : DST_ACC;
                end
                3'd1: begin
                    ctrl.dst       = ctrl.is_store ? DST_NONE : DST_ACC;
                    ctrl.lo_from_x = 1'b1;
                end
                3'd2: begin
                    ctrl.dst       = ctrl.is_store ? DST_NONE : DST_ACC;
                    ctrl.hi_from_y = 1'b1;
                end
                3'd3: begin
                    ctrl.dst       = ctrl.is_store ? DST_NONE : DST_ACC;
                    ctrl.lo_from_x = 1'b1;
                    ctrl.hi_from_y = 1'b1;
                end
                3'd4: begin
                    ctrl.dst = DST_X;
                end
                3'd5: begin
                    ctrl.dst = DST_Y;
                end
                3'd6: begin
                    ctrl.dst = ctrl.is_store ? DST_NONE : DST_OUT;
                end
                3'd7: begin
                    ctrl.dst       = ctrl.is_store ? DST_NONE : DST_OUT;
                    ctrl.lo_from_x = 1'b1;
                    ctrl.hi_from_y = 1'b1;
                    ctrl.bump_x    = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/octet_alu.sv
module octet_alu
    import octet_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] bus,
    output logic [W-1:0] result
);
    always_comb begin
        unique case (op)
            OP_LD:   result = bus;
            OP_AND:  result = acc & bus;
            OP_OR:   result = acc | bus;
            OP_XOR:  result = acc ^ bus;
            OP_ADD:  result = acc + bus;
            OP_SUB:  result = acc - bus;
            OP_ST:   result = acc;
            OP_BR:   result = '0 - acc;
            default: result = bus;
        endcase
    end
endmodule

// File: rtl/octet_branch.sv
module octet_branch #(
    parameter int W = 8
) (
    input  logic         is_branch,
    input  logic [2:0]   mode,
    input  logic [W-1:0] acc,
    output logic         taken
);
    logic [1:0] cond_idx;
    logic [3:0] mode_ext;

    always_comb begin
        // index 0: positive, 1: negative, 2: zero
        cond_idx = {(acc == '0), acc[W-1]};
        mode_ext = {1'b0, mode};
        taken    = is_branch && ((mode == 3'd0) || mode_ext[cond_idx]);
    end
endmodule

// File: rtl/octet_cpu.sv
module octet_cpu
    import octet_pkg::*;
#(
    parameter int         DW         = 8,
    parameter int         PC_W       = 16,
    parameter int         RAM_AW     = 15,
    parameter int         ROM_AW     = 8,
    parameter logic [7:0] UNDEF_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [ROM_AW-1:0] prog_addr,
    input  logic [2*DW-1:0]   prog_data,
    input  logic [DW-1:0]     in_port,
    output logic [DW-1:0]     out_port,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic              ram_we,
    input  logic [DW-1:0]     ram_rdata,
    output logic [PC_W-1:0]   fetch_addr
);
    localparam int              WORD_W   = 2 * DW;
    localparam logic [DW-1:0]   BYTE_ONE = DW'(1);
    localparam logic [PC_W-1:0] PC_ONE   = PC_W'(1);

    phase_e          phase_q, phase_d;
    logic            exec_en;
    logic [PC_W-1:0] pc_q, pc_next;
    logic [DW-1:0]   ac_q, x_q, y_q, out_q;
    logic [WORD_W-1:0] word;
    logic [DW-1:0]   ir, imm;
    ctrl_t           ctrl;
    logic [DW-1:0]   addr_lo, addr_hi;
    logic [DW-1:0]   bus;
    logic [DW-1:0]   alu_res;
    logic            taken;

    // Phase state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RESET;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        unique case (phase_q)
            PH_RESET: phase_d = PH_RUN;
            PH_RUN:   phase_d = PH_RUN;
            default:  phase_d = PH_RESET;
        endcase
    end

    // Phase outputs
    always_comb begin
        unique case (phase_q)
            PH_RESET: exec_en = 1'b0;
            PH_RUN:   exec_en = 1'b1;
            default:  exec_en = 1'b0;
        endcase
    end

    octet_progmem #(.AW(ROM_AW), .WW(WORD_W)) u_progmem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (prog_we && rst),
        .wr_addr (prog_addr),
        .wr_data (prog_data),
        .rd_addr (pc_q[ROM_AW-1:0]),
        .q       (word)
    );

    assign ir  = word[WORD_W-1:DW];
    assign imm = word[DW-1:0];

    octet_decode u_decode (
        .ir   (ir),
        .ctrl (ctrl)
    );

    // Effective address and bus source
    always_comb begin
        addr_lo = ctrl.lo_from_x ? x_q : imm;
        addr_hi = ctrl.hi_from_y ? y_q : '0;
        unique case (ctrl.src)
            SRC_IMM: bus = imm;
            SRC_MEM: bus = ctrl.is_store ? UNDEF_BYTE : ram_rdata;
            SRC_ACC: bus = ac_q;
            SRC_IN:  bus = in_port;
            default: bus = imm;
        endcase
    end

    octet_alu #(.W(DW)) u_alu (
        .op     (ctrl.op),
        .acc    (ac_q),
        .bus    (bus),
        .result (alu_res)
    );

    octet_branch #(.W(DW)) u_branch (
        .is_branch (ctrl.is_branch),
        .mode      (ctrl.mode),
        .acc       (ac_q),
        .taken     (taken)
    );

    always_comb begin
        pc_next = pc_q + PC_ONE;
        if (exec_en && taken) begin
            if (ctrl.far_jump) begin
                pc_next = {y_q, bus};
            end else begin
                pc_next = {pc_q[PC_W-1:DW], bus};
            end
        end
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ac_q  <= '0;
            x_q   <= '0;
            y_q   <= '0;
            out_q <= '0;
        end else begin
            pc_q <= pc_next;
            if (exec_en) begin
                unique case (ctrl.dst)
                    DST_ACC: ac_q  <= alu_res;
                    DST_X:   x_q   <= alu_res;
                    DST_Y:   y_q   <= alu_res;
                    DST_OUT: out_q <= alu_res;
                    default: ;
                endcase
                if (ctrl.bump_x) begin
                    x_q <= x_q + BYTE_ONE;
                end
            end
        end
    end

    assign ram_addr   = RAM_AW'({addr_hi, addr_lo});
    assign ram_wdata  = bus;
    assign ram_we     = exec_en && ctrl.is_store;
    assign out_port   = out_q;
    assign fetch_addr = pc_q;

    // R1
    reset_pc_chk: assert property (@(posedge clk)
        $fell(rst) |-> (fetch_addr == '0));

    // R7
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && ctrl.is_store) |=> ($stable(ac_q) && $stable(out_q)));

    // R8
    bump_x_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && ctrl.bump_x) |=> (x_q == $past(x_q) + BYTE_ONE));

    // R9
    far_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && ctrl.far_jump) |=> (pc_q == {$past(y_q), $past(bus)}));

    // R10
    near_branch_page_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && taken && !ctrl.far_jump) |=>
        (pc_q[PC_W-1:DW] == $past(pc_q[PC_W-1:DW])));
endmodule

// File: tb/test_octet_cpu.sv
module test_octet_cpu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [7:0] prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [7:0] in_r = '0;
    logic [7:0] out_port;
    logic [14:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       ram_we;
    logic [7:0] ram_rdata;
    logic [15:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit phase2 = 0;
    int unsigned seed = 32'h1F2E3D4C;

    logic [7:0] b_ram [0:4095];
    int m_ram [0:4095];
    int m_rom [0:255];
    int m_pc, m_ir, m_d, m_ac, m_x, m_y, m_out;
    bit m_run;
    string tag_pc = "R1";
    string tag_addr = "R1";

    always #10 clk = ~clk;

    octet_cpu i_octet_cpu (
        .clk        (clk),
        .rst        (rst),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .in_port    (in_r),
        .out_port   (out_port),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .ram_rdata  (ram_rdata),
        .fetch_addr (fetch_addr)
    );

    assign ram_rdata = b_ram[ram_addr[11:0]];
    always @(posedge clk) begin
        if (ram_we) b_ram[ram_addr[11:0]] <= ram_wdata;
    end

    function int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function int ins(int op, int md, int sr, int d);
        return ((op & 7) << 13) | ((md & 7) << 10) | ((sr & 3) << 8) | (d & 255);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model of one instruction on the current model state.
    task automatic eval(output int addr, output int bus, output bit we,
                        output int res, output int dest, output bit incx,
                        output int npc);
        int op, md, sr, lo, hi, c;
        bit st, br, tk;
        op = (m_ir >> 5) & 7;
        md = (m_ir >> 2) & 7;
        sr = m_ir & 3;
        st = (op == 6);
        br = (op == 7);
        lo = m_d; hi = 0; dest = 0; incx = 0;
        if (!br) begin
            if (md <= 3) dest = st ? 0 : 1;
            if (md == 1 || md == 3 || md == 7) lo = m_x;
            if (md == 2 || md == 3 || md == 7) hi = m_y;
            if (md == 4) dest = 2;
            if (md == 5) dest = 3;
            if (md >= 6) dest = st ? 0 : 4;
            if (md == 7) incx = 1;
        end
        addr = ((hi << 8) | lo) & 32767;
        case (sr)
            0: bus = m_d;
            1: bus = st ? 255 : m_ram[addr & 4095];
            2: bus = m_ac;
            default: bus = int'(in_r);
        endcase
        we = m_run && st;
        case (op)
            0: res = bus;
            1: res = m_ac & bus;
            2: res = m_ac | bus;
            3: res = m_ac ^ bus;
            4: res = (m_ac + bus) & 255;
            5: res = (m_ac - bus) & 255;
            6: res = m_ac;
            default: res = (256 - m_ac) & 255;
        endcase
        c = (m_ac >> 7) + ((m_ac == 0) ? 2 : 0);
        tk = br && (md == 0 || ((md >> c) & 1) == 1);
        if (br && md == 0) npc = ((m_y << 8) | bus) & 65535;
        else if (tk) npc = (m_pc & 65280) | bus;
        else npc = (m_pc + 1) & 65535;
    endtask

    // Reference model step, then comparison between edges.
    always @(posedge clk) begin
        int a, b, r, dst, np, kop, kmd;
        bit w, ix;
        if (rst) begin
            m_pc = 0; m_ir = 0; m_d = 0; m_ac = 0; m_x = 0; m_y = 0; m_out = 0;
            m_run = 0; tag_pc = "R1"; tag_addr = "R1";
        end else if (!m_run) begin
            m_ir = (m_rom[m_pc & 255] >> 8) & 255;
            m_d = m_rom[m_pc & 255] & 255;
            m_pc = (m_pc + 1) & 65535;
            m_run = 1;
            tag_pc = "R1"; tag_addr = "R1";
        end else begin
            kop = (m_ir >> 5) & 7;
            kmd = (m_ir >> 2) & 7;
            eval(a, b, w, r, dst, ix, np);
            if (w) m_ram[a & 4095] = b;
            case (dst)
                1: m_ac = r;
                2: m_x = r;
                3: m_y = r;
                4: m_out = r;
                default: ;
            endcase
            if (ix) m_x = (m_x + 1) & 255;
            m_ir = (m_rom[m_pc & 255] >> 8) & 255;
            m_d = m_rom[m_pc & 255] & 255;
            m_pc = np;
            if (kop == 7) tag_pc = (kmd == 0) ? "R9" : "R10";
            else tag_pc = phase2 ? "R2" : "R3";
            tag_addr = ix ? "R8" : "R5";
        end
        #5;
        if (!done) begin
            eval(a, b, w, r, dst, ix, np);
            chk(fetch_addr == 16'(m_pc), tag_pc, int'(fetch_addr), m_pc);
            chk(out_port == 8'(m_out), rst ? "R1" : "R4", int'(out_port), m_out);
            chk(ram_we == w, "R7", int'(ram_we), int'(w));
            chk(ram_addr == 15'(a), tag_addr, int'(ram_addr), a);
            chk(ram_wdata == 8'(b), "R6", int'(ram_wdata), b);
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            b_ram[i] = '0;
            m_ram[i] = 0;
        end
        for (int i = 0; i < 256; i++) m_rom[i] = int'(rnd() & 65535);
        // Directed prelude: ALU (R4), modes (R5), sources (R6), stores (R7)
        m_rom[8'h00] = ins(0, 0, 0, 8'h05);
        m_rom[8'h01] = ins(4, 0, 0, 8'h7E);
        m_rom[8'h02] = ins(6, 0, 2, 8'h10);
        m_rom[8'h03] = ins(0, 4, 0, 8'h20);
        m_rom[8'h04] = ins(0, 5, 0, 8'h01);
        m_rom[8'h05] = ins(6, 3, 2, 8'h00);
        m_rom[8'h06] = ins(0, 3, 1, 8'h00);
        m_rom[8'h07] = ins(1, 0, 0, 8'h0F);
        m_rom[8'h08] = ins(2, 0, 0, 8'h40);
        m_rom[8'h09] = ins(3, 0, 0, 8'hFF);
        m_rom[8'h0A] = ins(5, 0, 0, 8'hBD);
        m_rom[8'h0B] = ins(0, 6, 3, 8'h00);
        m_rom[8'h0C] = ins(0, 7, 2, 8'h00);
        m_rom[8'h0D] = ins(6, 7, 3, 8'h00);
        m_rom[8'h0E] = ins(6, 4, 0, 8'h33);
        m_rom[8'h0F] = ins(6, 0, 1, 8'h40);
        m_rom[8'h10] = ins(0, 1, 1, 8'h00);
        m_rom[8'h11] = ins(0, 2, 1, 8'h20);
        m_rom[8'h12] = ins(0, 0, 0, 8'h00);
        // Branches: zero taken (R10), negative taken, positive not taken, far (R9)
        m_rom[8'h13] = ins(7, 4, 0, 8'h20);
        m_rom[8'h14] = ins(0, 0, 0, 8'h80);
        m_rom[8'h20] = ins(7, 2, 0, 8'h30);
        m_rom[8'h21] = ins(0, 0, 0, 8'h80);
        m_rom[8'h30] = ins(7, 1, 0, 8'h50);
        m_rom[8'h31] = ins(0, 0, 0, 8'h02);
        m_rom[8'h32] = ins(7, 0, 0, 8'h40);
        m_rom[8'h33] = ins(0, 5, 0, 8'h00);
        m_rom[8'h40] = ins(7, 1, 0, 8'h60);
        m_rom[8'h41] = ins(0, 0, 0, 8'h7F);

        // R2: load the program while reset is held
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            prog_we = 1'b1;
            prog_addr = 8'(a);
            prog_data = 16'(m_rom[a]);
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // Main run with stray load-port writes (R2) and a changing input port
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            in_r = 8'(rnd());
            prog_we = rnd()[0];
            prog_addr = 8'(rnd());
            prog_data = 16'(rnd());
        end

        // Second reset without reload: the original program must still run
        @(negedge clk);
        rst = 1'b1;
        prog_we = 1'b0;
        repeat (3) @(negedge clk);
        phase2 = 1'b1;
        rst = 1'b0;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            in_r = 8'(rnd());
        end
        @(posedge clk);
        #7;
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule